// File: doc/BRIEF.md
# Byte-serial memory bus master

This block carries 32-bit memory reads and writes from a host port out over a narrow 8-bit bus to a slave device. The bus has an active-low chip select, an active-low write strobe, an active-low read strobe, a 3-bit lane code that says which byte is on the data lines, a direction control for the data lines and a ready input from the slave.

A write sends the four data bytes and then three address bytes. The slave raises ready when it has handled the access. A read sends only the three address bytes and waits for ready. It then releases the data lines and fetches the four data bytes from the most significant byte down. Every byte moves in two equal phases: a setup phase with all strobes high, then a strobe phase with chip select and one strobe low. Each phase lasts HOLD_CLKS clocks. If ready stays low for RDY_TIMEOUT clocks, the access ends with an error flag.

The host starts an access by pulsing `req_valid` while `idle` is high. It gets a one-cycle `ack` when the access finishes, with `rdata` and `err` valid in that cycle.

Top module: `bytebus_master`

## Requirements
- R1: A write puts bytes on lane codes 0,1,2,3,6,5,4 in that order. Lanes 0..3 carry write data bits [7:0], [15:8], [23:16], [31:24]. Lane 5 carries address bits [15:8] and lane 4 carries address bits [7:0].
- R2: In the lane-6 phase, data bits [5:0] carry address bits [21:16] and bits [7:6] carry a mode code: 2'b01 for a write, 2'b10 for a read.
- R3: Each byte first holds its lane code and data for HOLD_CLKS clocks with chip select and both strobes high. Chip select and one strobe are then low for exactly HOLD_CLKS clocks, and the lane code and data do not change across the two phases.
- R4: After the lane-4 phase the block waits for `bus_rdy` high. A write is acknowledged only after ready has been seen.
- R5: A read sends lanes 6,5,4 and waits for ready. It then fetches lanes 3,2,1,0 with chip select and the read strobe low and `bus_oe` low. The byte fetched on lane k lands in `rdata` bits [8k+7:8k].
- R6: The write strobe is never low while the data lines are released (`bus_oe` low), and the two strobes are never low together.
- R7: If ready is not high within RDY_TIMEOUT clocks of the wait starting, the access ends with `ack` and `err`=1 and no data fetch takes place. A successful access returns `err`=0.
- R8: `idle` is high only when no access is in progress. A `req_valid` pulse while busy is ignored. `ack` is a single-cycle pulse, and `idle` is high in the cycle after it.
- R9: After reset, chip select and both strobes are high, `bus_oe` is 1, `idle` is 1 and `ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | start an access (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | word address |
| req_wdata | input | 32 | write data |
| idle | output | 1 | ready for a new request |
| ack | output | 1 | one-cycle completion pulse |
| rdata | output | 32 | read data, valid with ack |
| err | output | 1 | ready timeout, valid with ack |
| bus_cs_n | output | 1 | chip select, active low |
| bus_wr_n | output | 1 | write strobe, active low |
| bus_rd_n | output | 1 | read strobe, active low |
| bus_lane | output | LANE_W | byte lane code |
| bus_dout | output | 8 | bus data driven by the block |
| bus_oe | output | 1 | 1 = block drives the data lines |
| bus_din | input | 8 | bus data from the slave |
| bus_rdy | input | 1 | slave ready |

## Verification
Writes and read-backs use data words whose four bytes all differ, so a swapped or misplaced lane shows up in `rdata`. Addresses have distinct values in each of the three address bytes, which exposes a wrong mode code or a shifted address field. Ready delays of zero, a few clocks and far past the timeout tell a premature acknowledge apart from a correct wait and from a correct error exit. A read of a location whose timed-out write was never committed, and a request pulsed while the block is busy, show that neither case leaves a trace in the slave or produces an extra acknowledge.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int ADDR_W   = 22;
  localparam int STEP_W   = 3;
  localparam logic [1:0] MODE_WR = 2'b01;
  localparam logic [1:0] MODE_RD = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_DONE
  } state_t;
endpackage

// File: rtl/bbm_hold_timer.sv
module bbm_hold_timer #(
  parameter int HOLD_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(HOLD_CLKS) + 1;
  logic [CW-1:0] cnt;

  assign last = run && (cnt == CW'(HOLD_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bbm_rdy_timer.sv
module bbm_rdy_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT) + 1;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bbm_byte_pick.sv
module bbm_byte_pick
  import bbm_pkg::*;
#(
  parameter int LANE_W = 3
) (
  input  logic                wr,
  input  logic [STEP_W-1:0]   step,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [LANE_W-1:0]   lane,
  output logic [7:0]          byte_o,
  output logic                rd_phase
);
  always_comb begin
    lane     = '0;
    byte_o   = '0;
    rd_phase = 1'b0;
    if (wr) begin
      case (step)
        3'd0: begin lane = LANE_W'(0); byte_o = wdata[7:0];   end
        3'd1: begin lane = LANE_W'(1); byte_o = wdata[15:8];  end
        3'd2: begin lane = LANE_W'(2); byte_o = wdata[23:16]; end
        3'd3: begin lane = LANE_W'(3); byte_o = wdata[31:24]; end
        3'd4: begin lane = LANE_W'(6); byte_o = {MODE_WR, addr[21:16]}; end
        3'd5: begin lane = LANE_W'(5); byte_o = addr[15:8]; end
        default: begin lane = LANE_W'(4); byte_o = addr[7:0]; end
      endcase
    end else begin
      case (step)
        3'd0: begin lane = LANE_W'(6); byte_o = {MODE_RD, addr[21:16]}; end
        3'd1: begin lane = LANE_W'(5); byte_o = addr[15:8]; end
        3'd2: begin lane = LANE_W'(4); byte_o = addr[7:0];  end
        3'd3: begin lane = LANE_W'(3); rd_phase = 1'b1; end
        3'd4: begin lane = LANE_W'(2); rd_phase = 1'b1; end
        3'd5: begin lane = LANE_W'(1); rd_phase = 1'b1; end
        default: begin lane = LANE_W'(0); rd_phase = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/bytebus_master.sv
module bytebus_master
  import bbm_pkg::*;
#(
  parameter int HOLD_CLKS   = 2,
  parameter int RDY_TIMEOUT = 64,
  parameter int LANE_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [21:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              idle,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic              bus_rd_n,
  output logic [LANE_W-1:0] bus_lane,
  output logic [7:0]        bus_dout,
  output logic              bus_oe,
  input  logic [7:0]        bus_din,
  input  logic              bus_rdy
);
  localparam logic [STEP_W-1:0] STEP_END    = STEP_W'(6);
  localparam logic [STEP_W-1:0] WR_ADDR_END = STEP_W'(6);
  localparam logic [STEP_W-1:0] RD_ADDR_END = STEP_W'(2);
  localparam logic [STEP_W-1:0] RD_DATA_1ST = STEP_W'(3);

  state_t              state_q, nxt_state;
  logic [STEP_W-1:0]   step_q, nxt_step;
  logic                wr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [31:0]         wdata_q;
  logic                accept, tmo_hit, capture;
  logic                hold_last, rdy_expired;
  logic                cur_wr;
  logic [ADDR_W-1:0]   cur_addr;
  logic [31:0]         cur_wdata;
  logic [LANE_W-1:0]   nxt_lane;
  logic [7:0]          nxt_byte;
  logic                nxt_rdphase, nxt_in_phase;

  bbm_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk(clk), .rst(rst),
    .run(state_q == ST_SETUP || state_q == ST_STROBE),
    .last(hold_last)
  );

  bbm_rdy_timer #(.LIMIT(RDY_TIMEOUT)) u_rdy (
    .clk(clk), .rst(rst),
    .run(state_q == ST_WAIT),
    .expired(rdy_expired)
  );

  assign cur_wr    = accept ? req_write : wr_q;
  assign cur_addr  = accept ? req_addr  : addr_q;
  assign cur_wdata = accept ? req_wdata : wdata_q;

  bbm_byte_pick #(.LANE_W(LANE_W)) u_pick (
    .wr(cur_wr), .step(nxt_step), .addr(cur_addr), .wdata(cur_wdata),
    .lane(nxt_lane), .byte_o(nxt_byte), .rd_phase(nxt_rdphase)
  );

  always_comb begin
    nxt_state = state_q;
    nxt_step  = step_q;
    accept    = 1'b0;
    tmo_hit   = 1'b0;
    capture   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        accept    = 1'b1;
        nxt_state = ST_SETUP;
        nxt_step  = '0;
      end
      ST_SETUP: if (hold_last) nxt_state = ST_STROBE;
      ST_STROBE: if (hold_last) begin
        capture = !bus_oe;
        if (step_q == (wr_q ? WR_ADDR_END : RD_ADDR_END)) nxt_state = ST_WAIT;
        else if (step_q == STEP_END) nxt_state = ST_DONE;
        else begin
          nxt_step  = step_q + 1'b1;
          nxt_state = ST_SETUP;
        end
      end
      ST_WAIT: begin
        if (bus_rdy) begin
          if (wr_q) nxt_state = ST_DONE;
          else begin
            nxt_state = ST_SETUP;
            nxt_step  = RD_DATA_1ST;
          end
        end else if (rdy_expired) begin
          nxt_state = ST_DONE;
          tmo_hit   = 1'b1;
        end
      end
      ST_DONE: nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign nxt_in_phase = (nxt_state == ST_SETUP) || (nxt_state == ST_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata    <= '0;
      err      <= 1'b0;
      idle     <= 1'b1;
      ack      <= 1'b0;
      bus_cs_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_lane <= '0;
      bus_dout <= '0;
      bus_oe   <= 1'b1;
    end else begin
      state_q <= nxt_state;
      step_q  <= nxt_step;
      if (accept) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        rdata   <= '0;
        err     <= 1'b0;
      end
      if (tmo_hit) err <= 1'b1;
      if (capture)
        rdata <= (rdata & ~(32'hFF << (8 * bus_lane))) |
                 ({24'b0, bus_din} << (8 * bus_lane));
      idle     <= (nxt_state == ST_IDLE);
      ack      <= (nxt_state == ST_DONE);
      bus_cs_n <= !(nxt_state == ST_STROBE);
      bus_wr_n <= !(nxt_state == ST_STROBE && !nxt_rdphase);
      bus_rd_n <= !(nxt_state == ST_STROBE && nxt_rdphase);
      bus_lane <= nxt_in_phase ? nxt_lane : '0;
      bus_dout <= nxt_in_phase ? nxt_byte : 8'h00;
      bus_oe   <= !(nxt_in_phase && nxt_rdphase);
    end
  end
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
  parameter int LANE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs_n,
  input logic              bus_wr_n,
  input logic              bus_rd_n,
  input logic              bus_oe,
  input logic [LANE_W-1:0] bus_lane,
  input logic [7:0]        bus_dout,
  input logic              ack,
  input logic              err,
  input logic              idle
);
  p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(!bus_wr_n && !bus_rd_n));
  p_no_write_released_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> bus_wr_n);
  p_read_released_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (!bus_oe && !bus_cs_n));
  p_lane_held_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_lane) && $stable(bus_dout)));
  p_setup_first_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs_n) |-> ($stable(bus_lane) && $stable(bus_dout)));
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  p_ack_then_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ack |=> idle);
  p_err_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ack);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    idle |-> (bus_cs_n && bus_oe));
endmodule

bind bytebus_master bbm_checker #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
  .bus_rd_n(bus_rd_n), .bus_oe(bus_oe), .bus_lane(bus_lane),
  .bus_dout(bus_dout), .ack(ack), .err(err), .idle(idle)
);

// File: tb/sim_bytebus_master.sv
module sim_bytebus_master;
  localparam int HOLD = 2;
  localparam int TMO  = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic idle, ack, err, bus_cs_n, bus_wr_n, bus_rd_n, bus_oe;
  logic [31:0] rdata;
  logic [2:0] bus_lane;
  logic [7:0] bus_dout, bus_din;
  logic bus_rdy = 1'b1;

  always #2 clk = ~clk;

  bytebus_master #(.HOLD_CLKS(HOLD), .RDY_TIMEOUT(TMO), .LANE_W(3)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .ack(ack),
    .rdata(rdata), .err(err), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_lane(bus_lane), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  typedef struct {
    bit          wr;
    bit          err;
    logic [31:0] rd;
    logic [20:0] seq;
    int          n;
    logic [1:0]  mode;
  } exp_t;
  exp_t exq[$];

  // slave model state
  logic [31:0] slave_mem [int];
  logic [31:0] exp_mem [int];
  logic [21:0] s_addr = '0;
  logic [31:0] s_wdata = '0, s_rdword = '0;
  int rdy_delay = 0, countdown = 0;
  bit pend = 0, pend_wr = 0, rdy_seen = 0, prev_cs = 1;
  logic [20:0] got_seq = '0;
  int got_n = 0, low_cnt = 0, width_bad = 0, oe_bad = 0;
  logic [1:0] got_mode = '0;

  assign bus_din = (!bus_rd_n && !bus_cs_n) ? 8'(s_rdword >> (8 * bus_lane)) : 8'h00;

  function automatic logic [31:0] mem_get(input logic [31:0] m [int], input int a);
    return m.exists(a) ? m[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_cs_n && prev_cs) begin
        got_seq = got_seq | (21'(bus_lane) << (3 * got_n));
        got_n++;
        low_cnt = 0;
        if (!bus_rd_n && bus_oe) oe_bad++;
        if (!bus_wr_n) begin
          if (!bus_oe) oe_bad++;
          case (bus_lane)
            3'd0: s_wdata[7:0]   = bus_dout;
            3'd1: s_wdata[15:8]  = bus_dout;
            3'd2: s_wdata[23:16] = bus_dout;
            3'd3: s_wdata[31:24] = bus_dout;
            3'd6: begin
              got_mode = bus_dout[7:6];
              s_addr[21:16] = bus_dout[5:0];
              bus_rdy = 1'b0; pend = 0;
            end
            3'd5: s_addr[15:8] = bus_dout;
            3'd4: begin
              s_addr[7:0] = bus_dout;
              pend = 1; pend_wr = (got_mode == 2'b01); countdown = rdy_delay;
            end
            default: ;
          endcase
        end
      end
      if (!bus_cs_n) low_cnt++;
      if (bus_cs_n && !prev_cs && low_cnt != HOLD) width_bad++;
      prev_cs = bus_cs_n;
      if (pend) begin
        if (countdown == 0) begin
          bus_rdy = 1'b1; pend = 0; rdy_seen = 1;
          if (pend_wr) slave_mem[int'(s_addr)] = s_wdata;
          else s_rdword = mem_get(slave_mem, int'(s_addr));
        end else countdown--;
      end
      // scoreboard monitor
      if (ack) begin
        if (exq.size() == 0) chk(0, "R8 ack with no access pending", 1, 0);
        else begin
          exp_t e;
          e = exq.pop_front();
          chk(err == e.err, "R7 error flag", 32'(err), 32'(e.err));
          chk(got_seq == e.seq && got_n == e.n, "R1/R5 lane order",
              32'(got_seq), 32'(e.seq));
          chk(got_mode == e.mode, "R2 mode code", 32'(got_mode), 32'(e.mode));
          chk(width_bad == 0, "R3 strobe width", 32'(width_bad), 0);
          chk(oe_bad == 0, "R6 data line direction", 32'(oe_bad), 0);
          if (!e.err) chk(rdy_seen, "R4 ack after ready", 32'(rdy_seen), 1);
          if (!e.wr && !e.err) chk(rdata == e.rd, "R5 read data", rdata, e.rd);
        end
        got_seq = '0; got_n = 0; width_bad = 0; oe_bad = 0; rdy_seen = 0;
      end
    end
  end

  task automatic start_req(input bit wr, input logic [21:0] a, input logic [31:0] d,
                           input int delay);
    exp_t e;
    while (!idle) @(negedge clk);
    rdy_delay = delay;
    e.wr = wr;
    e.err = (delay > TMO);
    e.mode = wr ? 2'b01 : 2'b10;
    e.rd = mem_get(exp_mem, int'(a));
    if (wr) begin
      e.seq = {3'd4, 3'd5, 3'd6, 3'd3, 3'd2, 3'd1, 3'd0};
      e.n = 7;
      if (!e.err) exp_mem[int'(a)] = d;
    end else if (e.err) begin
      e.seq = {12'd0, 3'd4, 3'd5, 3'd6};
      e.n = 3;
    end else begin
      e.seq = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
      e.n = 7;
    end
    exq.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_req();
    while (exq.size() > 0) @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [21:0] a, input logic [31:0] d,
                        input int delay);
    start_req(wr, a, d, delay);
    finish_req();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(bus_cs_n, "R9 chip select high", 32'(bus_cs_n), 1);
    chk(bus_wr_n && bus_rd_n, "R9 strobes high", 32'({bus_wr_n, bus_rd_n}), 3);
    chk(bus_oe, "R9 data lines driven", 32'(bus_oe), 1);
    chk(idle, "R9 idle", 32'(idle), 1);
    chk(!ack, "R9 no ack", 32'(ack), 0);

    // R1 R2 R4 write then R5 read-back with differing bytes
    access(1, 22'h2A55C3, 32'hDEADBEEF, 3);
    access(0, 22'h2A55C3, 32'h0, 5);
    access(1, 22'h000001, 32'h01020304, 0);
    access(0, 22'h000001, 32'h0, 0);
    access(0, 22'h100000, 32'h0, 2);       // never written: zero
    access(1, 22'h3FFFFF, 32'h80C0E0F1, 20);
    access(0, 22'h3FFFFF, 32'h0, 20);

    // R7 write timeout: not committed, err set
    access(1, 22'h012345, 32'hCAFEF00D, 1000);
    access(0, 22'h012345, 32'h0, 1);
    // R7 read timeout: only address lanes
    access(0, 22'h2A55C3, 32'h0, 1000);
    access(0, 22'h2A55C3, 32'h0, 4);

    // R8 request while busy is ignored
    start_req(1, 22'h054321, 32'h11223344, 6);
    repeat (3) @(negedge clk);
    chk(!idle, "R8 idle low while busy", 32'(idle), 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 22'h0ABCDE; req_wdata = 32'h55555555;
    @(negedge clk);
    req_valid = 1'b0;
    finish_req();
    repeat (50) @(negedge clk);
    chk(idle, "R8 idle after access", 32'(idle), 1);
    access(0, 22'h0ABCDE, 32'h0, 2);
    access(0, 22'h054321, 32'h0, 2);
    summary();
  end
endmodule